// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. Each operation takes an accumulator value and a second operand and works out the result from them. The block holds its own five-bit status state (sign, zero, auxiliary carry, parity, carry). It reads that state as the incoming carry and nibble-carry for the operations that need it, and it writes back the updated flags. Operand selection, register files and instruction decoding happen elsewhere. The block only sees a 4-bit operation code and a one-cycle enable.

Every flag follows the rule of the operation that ran. Add and subtract set every flag from the arithmetic. Subtract reports a borrow in the carry flag. The logic operations force the carry flags to fixed values. Rotates touch only the carry. Complement changes no flag. Decimal adjust runs two conditional correction steps. The result and the flags are registered. An operation issued at one rising edge shows at the outputs right after that edge. The flags come out as one byte, so surrounding logic can push and pop them as a single word.

Top module: `alu8_flags`

## Requirements
- R1: Synchronous active-high reset clears the result register to 0x00, drops `res_we`, and sets the flag byte to 0x02.
- R2: The flag byte holds S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bit 1 always reads 1 and bits 5 and 3 always read 0.
- R3: Opcode 0 adds A+B and opcode 1 adds A+B+CY. The result is written. CY is the carry out of bit 7 and AC is the carry from bit 3 into bit 4. S copies bit 7 of the result, Z is set when the result is zero, and P is set when the result has an even number of ones.
- R4: Opcode 2 computes A-B and opcode 3 computes A-B-CY. The result is written. CY is set when a borrow occurs. AC is the carry out of the low nibble of A + ~B + (1 - borrow-in). S, Z and P come from the result as in R3.
- R5: Opcode 4 (compare) sets all five flags exactly as opcode 2 would. It does not write and does not change the result register. CY=1 when A<B, and Z=1 when A=B.
- R6: Opcode 5 (AND) sets AC=1 and CY=0. Opcode 6 (OR) and opcode 7 (XOR) clear both AC and CY. S, Z and P come from the result.
- R7: Opcode 8 writes ~A and leaves all flags unchanged.
- R8: Opcode 9 rotates left with bit 7 going to both CY and bit 0. Opcode 10 rotates right with bit 0 going to both CY and bit 7. Opcode 11 rotates left through the carry and opcode 12 rotates right through the carry, with the old CY filling the vacated bit. All four write the result. S, Z, AC and P are unchanged.
- R9: Opcode 13 sets CY and opcode 14 inverts CY. Neither writes a result, and the other flags are unchanged.
- R10: Opcode 15 (decimal adjust) first adds 0x06 when the low nibble is above 9 or AC=1. It then adds 0x60 when the high nibble of that intermediate value is above 9, or CY was set, or the first step carried. It writes the result. AC is the low-nibble carry of the first step. CY is set if either step carries and is never cleared by this operation. S, Z and P come from the result.
- R11: With `op_en` low, `res_we` is 0 after the next edge and both the result and the flags hold their values. With `op_en` high, the result, `res_we` and the flags reflect the operation one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Perform the operation on this edge |
| op_code | input | 4 | Operation select (see requirements) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| res_out | output | 8 | Last written result |
| res_we | output | 1 | The last operation wrote `res_out` |
| flags_out | output | 8 | Packed status byte |

## Verification
The hardest case to reach is the decimal-adjust path where the second correction fires only because the first correction carried, or where CY comes in already set and must stay set. Random operand pairs seldom line these up with the right incoming flags. The stimulus therefore chains operations: an add or set-carry first puts AC and CY into chosen states, and decimal adjust then runs on boundary values such as 0x9A, 0xFA and 0x99. Long random sequences then carry flags from one operation into the next, so the add-with-carry, subtract-with-borrow and through-carry rotates run with both values of the incoming carry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPC_W = 4;
  localparam int FLAG_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_CMP = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_CMA = 4'd8,  OP_RLC = 4'd9,  OP_RRC = 4'd10, OP_RAL = 4'd11,
    OP_RAR = 4'd12, OP_STC = 4'd13, OP_CMC = 4'd14, OP_DAA = 4'd15
  } alu_op_e;

  localparam int FB_CY  = 0;
  localparam int FB_ONE = 1;
  localparam int FB_P   = 2;
  localparam int FB_AC  = 4;
  localparam int FB_Z   = 6;
  localparam int FB_S   = 7;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic [FLAG_W-1:0] flag_byte(flags_t f);
    logic [FLAG_W-1:0] b;
    b         = '0;
    b[FB_ONE] = 1'b1;
    b[FB_S]   = f.s;
    b[FB_Z]   = f.z;
    b[FB_AC]  = f.ac;
    b[FB_P]   = f.p;
    b[FB_CY]  = f.cy;
    return b;
  endfunction
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_half,
  output logic         c_out
);
  localparam int H = W / 2;
  localparam int U = W - H;

  logic [H:0] lo;
  logic [U:0] hi;

  assign lo     = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
  assign hi     = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{U{1'b0}}, lo[H]};
  assign sum    = {hi[U-1:0], lo[H-1:0]};
  assign c_half = lo[H];
  assign c_out  = hi[U];
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_cy,
  input  logic         cy_in,
  output logic [W-1:0] sum,
  output logic         ac,
  output logic         cy
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic         c_half;
  logic         c_out;

  assign b_eff = sub ? ~b : b;
  assign cin   = sub ? ~(use_cy & cy_in) : (use_cy & cy_in);

  alu8_adder #(.W(W)) add_i (
    .a(a), .b(b_eff), .cin(cin),
    .sum(sum), .c_half(c_half), .c_out(c_out)
  );

  assign ac = c_half;
  assign cy = sub ? ~c_out : c_out;
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  logic         dir_right,
  input  logic         thru,
  output logic [W-1:0] res,
  output logic         cy_out
);
  logic fill;

  always_comb begin
    if (dir_right) begin
      cy_out = a[0];
      fill   = thru ? cy_in : a[0];
      res    = {fill, a[W-1:1]};
    end else begin
      cy_out = a[W-1];
      fill   = thru ? cy_in : a[W-1];
      res    = {a[W-2:0], fill};
    end
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         ac_in,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         ac_out,
  output logic         cy_out
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LO_FIX = W'(6);
  localparam logic [W-1:0] HI_FIX = W'(6) << H;

  logic         lo_need;
  logic         hi_need;
  logic [W-1:0] step1;
  logic         c_half1;
  logic         c_out1;
  logic [W:0]   step2;

  assign lo_need = (a[H-1:0] > H'(9)) | ac_in;

  alu8_adder #(.W(W)) lo_i (
    .a(a), .b(lo_need ? LO_FIX : '0), .cin(1'b0),
    .sum(step1), .c_half(c_half1), .c_out(c_out1)
  );

  assign hi_need = (step1[W-1:H] > (W-H)'(9)) | cy_in | c_out1;
  assign step2   = {1'b0, step1} + {1'b0, (hi_need ? HI_FIX : '0)};

  assign res    = step2[W-1:0];
  assign ac_out = c_half1;
  assign cy_out = cy_in | c_out1 | step2[W];
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_en,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  output logic [DATA_W-1:0] res_out,
  output logic              res_we,
  output logic [FLAG_W-1:0] flags_out
);
  alu_op_e op;
  flags_t  flags_q;
  flags_t  flags_d;

  logic [DATA_W-1:0] ar_sum;
  logic              ar_ac;
  logic              ar_cy;
  logic [DATA_W-1:0] rot_res;
  logic              rot_cy;
  logic [DATA_W-1:0] daa_res;
  logic              daa_ac;
  logic              daa_cy;

  logic [DATA_W-1:0] nres;
  logic              nwe;
  logic              upd_szp;
  logic [DATA_W-1:0] res_q;
  logic              we_q;

  assign op = alu_op_e'(op_code);

  alu8_arith #(.W(DATA_W)) arith_i (
    .a(acc_in), .b(opnd_in),
    .sub(op == OP_SUB || op == OP_SBB || op == OP_CMP),
    .use_cy(op == OP_ADC || op == OP_SBB),
    .cy_in(flags_q.cy),
    .sum(ar_sum), .ac(ar_ac), .cy(ar_cy)
  );

  alu8_rotate #(.W(DATA_W)) rot_i (
    .a(acc_in), .cy_in(flags_q.cy),
    .dir_right(op == OP_RRC || op == OP_RAR),
    .thru(op == OP_RAL || op == OP_RAR),
    .res(rot_res), .cy_out(rot_cy)
  );

  alu8_daa #(.W(DATA_W)) daa_i (
    .a(acc_in), .ac_in(flags_q.ac), .cy_in(flags_q.cy),
    .res(daa_res), .ac_out(daa_ac), .cy_out(daa_cy)
  );

  always_comb begin
    flags_d = flags_q;
    nres    = acc_in;
    nwe     = 1'b0;
    upd_szp = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        nres       = ar_sum;
        nwe        = (op != OP_CMP);
        flags_d.ac = ar_ac;
        flags_d.cy = ar_cy;
        upd_szp    = 1'b1;
      end
      OP_AND: begin
        nres       = acc_in & opnd_in;
        nwe        = 1'b1;
        flags_d.ac = 1'b1;
        flags_d.cy = 1'b0;
        upd_szp    = 1'b1;
      end
      OP_OR, OP_XOR: begin
        nres       = (op == OP_OR) ? (acc_in | opnd_in) : (acc_in ^ opnd_in);
        nwe        = 1'b1;
        flags_d.ac = 1'b0;
        flags_d.cy = 1'b0;
        upd_szp    = 1'b1;
      end
      OP_CMA: begin
        nres = ~acc_in;
        nwe  = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        nres       = rot_res;
        nwe        = 1'b1;
        flags_d.cy = rot_cy;
      end
      OP_STC: flags_d.cy = 1'b1;
      OP_CMC: flags_d.cy = ~flags_q.cy;
      OP_DAA: begin
        nres       = daa_res;
        nwe        = 1'b1;
        flags_d.ac = daa_ac;
        flags_d.cy = daa_cy;
        upd_szp    = 1'b1;
      end
      default: ;
    endcase
    if (upd_szp) begin
      flags_d.s = nres[DATA_W-1];
      flags_d.z = (nres == '0);
      flags_d.p = ~^nres;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      we_q <= op_en & nwe;
      if (op_en) begin
        flags_q <= flags_d;
        if (nwe) res_q <= nres;
      end
    end
  end

  assign res_out   = res_q;
  assign res_we    = we_q;
  assign flags_out = flag_byte(flags_q);
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_en,
  input logic [OPC_W-1:0]  op_code,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] res_out,
  input logic              res_we,
  input logic [FLAG_W-1:0] flags_out
);
  logic is_rot;
  logic is_szp;
  assign is_rot = (op_code == OP_RLC) || (op_code == OP_RRC) ||
                  (op_code == OP_RAL) || (op_code == OP_RAR);
  assign is_szp = (op_code <= OP_XOR) || (op_code == OP_DAA);

  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    flags_out[1] && !flags_out[3] && !flags_out[5]);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> !res_we && $stable(flags_out) && $stable(res_out));

  // R7
  cma_flags_chk: assert property (@(posedge clk) disable iff (rst)
    op_en && op_code == OP_CMA |=> $stable(flags_out) && res_out == ~$past(acc_in));

  // R8
  rot_flags_chk: assert property (@(posedge clk) disable iff (rst)
    op_en && is_rot |=> flags_out[7:1] == $past(flags_out[7:1]));

  // R9
  stc_chk: assert property (@(posedge clk) disable iff (rst)
    op_en && op_code == OP_STC |=> flags_out[0] && !res_we && $stable(flags_out[7:1]));

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    op_en && op_code == OP_CMP |=> !res_we && $stable(res_out));

  // R6
  and_flags_chk: assert property (@(posedge clk) disable iff (rst)
    op_en && op_code == OP_AND |=> flags_out[4] && !flags_out[0]);

  // R3
  szp_match_chk: assert property (@(posedge clk) disable iff (rst)
    op_en && is_szp && op_code != OP_CMP |=>
      flags_out[7] == res_out[DATA_W-1] && flags_out[6] == (res_out == '0) &&
      flags_out[2] == ~^res_out);

  // R10
  daa_cy_keep_chk: assert property (@(posedge clk) disable iff (rst)
    op_en && op_code == OP_DAA && flags_out[0] |=> flags_out[0]);
endmodule

bind alu8_flags alu8_flags_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code), .acc_in(acc_in),
  .res_out(res_out), .res_we(res_we), .flags_out(flags_out)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_en;
  logic [3:0] op_code;
  logic [7:0] acc_in, opnd_in;
  logic [7:0] res_out;
  logic       res_we;
  logic [7:0] flags_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [7:0] m_res;
  logic [7:0] m_flags;

  always #4 clk = ~clk;

  alu8_flags dut (
    .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in),
    .res_out(res_out), .res_we(res_we), .flags_out(flags_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_flags(bit s, bit z, bit ac, bit p, bit cy);
    return {s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
  endfunction

  function automatic bit even_ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:   return "R3";
      2, 3:   return "R4";
      4:      return "R5";
      5, 6, 7: return "R6";
      8:      return "R7";
      9, 10, 11, 12: return "R8";
      13, 14: return "R9";
      default: return "R10";
    endcase
  endfunction

  // returns {we, result, flag byte}
  function automatic logic [16:0] model(int a, int b, int op, logic [7:0] f);
    bit cy = f[0], ac = f[4];
    bit s = f[7], z = f[6], p = f[2];
    bit we = 0, szp = 0;
    int r = a, t, lo;
    case (op)
      0, 1: begin
        t = a + b + ((op == 1) ? cy : 0);
        ac = ((a & 15) + (b & 15) + ((op == 1) ? cy : 0)) > 15;
        cy = t > 255; r = t & 255; we = 1; szp = 1;
      end
      2, 3, 4: begin
        int bin = (op == 3) ? cy : 0;
        t = a - b - bin;
        ac = ((a & 15) + ((~b) & 15) + (1 - bin)) > 15;
        cy = t < 0; r = t & 255; we = (op != 4); szp = 1;
      end
      5: begin r = a & b; ac = 1; cy = 0; we = 1; szp = 1; end
      6: begin r = a | b; ac = 0; cy = 0; we = 1; szp = 1; end
      7: begin r = a ^ b; ac = 0; cy = 0; we = 1; szp = 1; end
      8: begin r = (~a) & 255; we = 1; end
      9:  begin r = ((a << 1) | (a >> 7)) & 255; cy = a[7]; we = 1; end
      10: begin r = ((a >> 1) | (a << 7)) & 255; cy = a[0]; we = 1; end
      11: begin r = ((a << 1) | cy) & 255; cy = a[7]; we = 1; end
      12: begin r = ((a >> 1) | (cy << 7)) & 255; cy = a[0]; we = 1; end
      13: cy = 1;
      14: cy = !cy;
      default: begin
        t = a;
        lo = a & 15;
        if (lo > 9 || ac) begin ac = (lo + 6) > 15; t = t + 6; end
        else ac = 0;
        if (t > 255) cy = 1;
        t = t & 255;
        if ((t >> 4) > 9 || cy) begin t = t + 'h60; if (t > 255) cy = 1; end
        r = t & 255; we = 1; szp = 1;
      end
    endcase
    if (szp) begin s = r[7]; z = (r == 0); p = even_ones(r); end
    return {we, r[7:0], mk_flags(s, z, ac, p, cy)};
  endfunction

  task automatic do_op(input int op, input int a, input int b);
    logic [16:0] e;
    string tg;
    op_en = 1; op_code = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0];
    e = model(a, b, op, m_flags);
    @(negedge clk);
    tg = tag_of(op);
    if (e[16]) m_res = e[15:8];
    m_flags = e[7:0];
    chk(flags_out == m_flags, tg, flags_out, m_flags);
    chk(res_we == e[16], tg, res_we, e[16]);
    chk(res_out == m_res, tg, res_out, m_res);
    chk((flags_out & 8'h2A) == 8'h02, "R2", flags_out, m_flags);
  endtask

  task automatic idle(input int a);
    op_en = 0; op_code = 4'd0; acc_in = a[7:0]; opnd_in = 8'hFF;
    @(negedge clk);
    chk(res_we == 0, "R11", res_we, 0);
    chk(flags_out == m_flags, "R11", flags_out, m_flags);
    chk(res_out == m_res, "R11", res_out, m_res);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0085));
    rst = 1; op_en = 0; op_code = 0; acc_in = 0; opnd_in = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(flags_out == 8'h02, "R1", flags_out, 8'h02);
    chk(res_we == 0, "R1", res_we, 0);
    chk(res_out == 8'h00, "R1", res_out, 0);
    m_res = 8'h00; m_flags = 8'h02;

    // R3 carry and half-carry boundaries
    do_op(0, 8'hFF, 8'h01);
    do_op(1, 8'h0F, 8'h00);
    do_op(0, 8'h7F, 8'h01);
    // R4 borrow
    do_op(2, 8'h00, 8'h01);
    do_op(3, 8'h10, 8'h0F);
    // R5 compare: equal, less, greater
    do_op(4, 8'h55, 8'h55);
    do_op(4, 8'h10, 8'h20);
    do_op(4, 8'h30, 8'h20);
    // R6 logic
    do_op(5, 8'hF0, 8'h0F);
    do_op(6, 8'h00, 8'h00);
    do_op(7, 8'hAA, 8'h55);
    // R7
    do_op(8, 8'h3C, 8'h00);
    // R8 rotates with CY in both states
    do_op(13, 0, 0);
    do_op(11, 8'h01, 0);
    do_op(12, 8'h80, 0);
    do_op(9, 8'h81, 0);
    do_op(10, 8'h01, 0);
    // R9
    do_op(14, 0, 0);
    do_op(14, 0, 0);
    // R10 decimal adjust corners
    do_op(0, 8'h15, 8'h27);
    do_op(15, 8'h3C, 0);
    do_op(2, 8'h20, 8'h30);
    do_op(15, 8'h9A, 0);
    do_op(6, 0, 0);
    do_op(15, 8'h9A, 0);
    do_op(6, 0, 0);
    do_op(15, 8'hFA, 0);
    do_op(13, 0, 0);
    do_op(15, 8'h99, 0);
    do_op(0, 8'h09, 8'h08);
    do_op(15, 8'h11, 0);
    // R11 idle holds state
    idle(8'h12);
    idle(8'h34);

    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 15);
      int a = $urandom_range(0, 255);
      int b = $urandom_range(0, 255);
      if ($urandom_range(0, 15) == 0) idle(a);
      else do_op(op, a, b);
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule